// File: doc/BRIEF.md
# Serial-Controlled Eight-Channel Switch Controller

This block is the digital control core of an eight-channel output switch. A host sends an 8-bit command over a four-wire serial link (serial clock, active-low chip select, serial data in, serial data out). In the same frame the block returns an 8-bit status word. When chip select rises after exactly eight clocks, the command sets the eight channel-enable outputs. Any other bit count discards the frame.

Each channel has an overcurrent flag and a drain-level sense input. A single protect-disable input picks how overcurrent is handled. With the input low, an overcurrent shuts off only the affected channel and holds it off. With the input high, the channel stays on in current limit. The status bit of a channel reads 1 when it is off, latched off, current-limiting or sensing its drain high. It reads 0 when it is on and healthy.

The serial pins, the fault flags and the protect-disable input are all resynchronized to the system clock. An active-low clear pin is asserted asynchronously and released synchronously. It forces all channels off without disturbing the serial data output.

Top module: `osw_ctrl`

## Requirements
- R1: The data-out enable `so_oe` goes to 1 after chip select falls and returns to 0 after chip select rises; it is 0 whenever no frame is in progress.
- R2: Status leaves most significant bit first. Bit 7, which is channel 7, is on `so` as soon as the frame starts. Each rising serial-clock edge advances `so` to the next lower bit. The serial clock idles high and the host samples `so` at each falling edge.
- R3: Command bits are sampled at falling serial-clock edges, most significant first. When chip select rises after exactly eight bits, bit k of the command sets `out_en[k]` (1 means on).
- R4: Status bit k is 1 when channel k is off, has its overcurrent flag set, or senses its drain high. It is 0 when channel k is on with no overcurrent and its drain low.
- R5: A frame with fewer or more than eight serial-clock falling edges leaves `out_en` unchanged.
- R6: With `prot_dis` low, an overcurrent on an enabled channel latches that channel off. Every other channel keeps its state.
- R7: A latched-off channel stays off, even after its overcurrent is gone, until a valid frame commands it off or the clear pin is asserted. A latched-off channel that is commanded on again stays off.
- R8: With `prot_dis` high, an overcurrent does not turn its channel off. The channel reports status 1 while the flag is set.
- R9: Driving `clr_n` low turns every channel off and clears the command and the fault latches. A frame in progress while it is low is discarded.
- R10: `clr_n` changes neither `so` nor `so_oe`.
- R11: System reset `rst` (synchronous, active high) leaves all channels off and `so_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| clr_n | input | 1 | Active-low functional clear, asynchronous assertion |
| sclk | input | 1 | Serial clock from host, idle high |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial command data in |
| so | output | 1 | Serial status data out |
| so_oe | output | 1 | Output enable for the `so` pad driver (tri-state control) |
| prot_dis | input | 1 | 1: current-limit mode, 0: latch-off on overcurrent |
| ovc | input | CH | Per-channel overcurrent flags |
| drain_hi | input | CH | Per-channel drain-level sense, 1 = drain high |
| out_en | output | CH | Per-channel switch enables, 1 = on |

## Verification
A table of frames steps the controller through a chain of commands. Each row's status depends on the state the previous row left behind. The patterns are:
- A checkerboard command after reset, then a disjoint command with one enabled drain reading high. These separate the off-reports from the drain-reports and expose bit-order errors.
- An overcurrent on an enabled channel with protection active, held across later frames that command the channel on, then off, then on again. This distinguishes a latch from a plain mask.
- The same flag with protection disabled, which must change status but not the enables.
- Seven-bit and nine-bit frames, which must leave the enables as they were.

Directed steps then pulse the clear pin in the middle of a frame. They check the data-out line and the enables, and confirm that the cleared latch lets its channel turn on again.

// File: rtl/osw_pkg.sv
`timescale 1ns/1ps
package osw_pkg;
  localparam int unsigned OSW_CH_DEF   = 8;
  localparam int unsigned OSW_SYNC_DEF = 2;

  // status bit of one channel: 1 = off, overcurrent or drain high
  function automatic logic osw_status(input logic en, input logic oc, input logic dh);
    return ~en | oc | dh;
  endfunction
endpackage

// File: rtl/osw_sync.sv
`timescale 1ns/1ps
module osw_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/osw_clr_sync.sv
`timescale 1ns/1ps
module osw_clr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic clr_act
);
  logic [STAGES-1:0] chain;

  // asserts at once, releases after STAGES clocks
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign clr_act = chain[STAGES-1];
endmodule

// File: rtl/osw_frame.sv
`timescale 1ns/1ps
module osw_frame #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         sclk_fall,
  input  logic         sclk_rise,
  input  logic         si_s,
  input  logic [W-1:0] status,
  output logic         so,
  output logic         so_oe,
  output logic [W-1:0] cmd_word,
  output logic         cmd_load
);
  localparam int unsigned CW = $clog2(W + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_OVER = CW'(W + 1);

  logic [W-1:0]  tx_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic          bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      bad_q <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      if (cs_fall) begin
        tx_q  <= status;
        cnt_q <= '0;
        bad_q <= 1'b0;
        so_oe <= 1'b1;
      end else begin
        if (cs_rise) so_oe <= 1'b0;
        if (sclk_rise && so_oe) tx_q <= {tx_q[W-2:0], 1'b0};
        if (sclk_fall && so_oe) begin
          rx_q <= {rx_q[W-2:0], si_s};
          if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        end
      end
      if (clr) begin
        rx_q  <= '0;
        bad_q <= 1'b1;
      end
    end
  end

  assign so       = tx_q[W-1];
  assign cmd_word = rx_q;
  assign cmd_load = cs_rise && (cnt_q == CNT_FULL) && !bad_q;
endmodule

// File: rtl/osw_channel.sv
`timescale 1ns/1ps
module osw_channel
  import osw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cmd_load,
  input  logic cmd_bit,
  input  logic oc,
  input  logic pd,
  input  logic dh,
  output logic cmd_on,
  output logic latched,
  output logic en,
  output logic stat
);
  logic trip;
  assign trip = oc & ~pd;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cmd_on  <= 1'b0;
      latched <= 1'b0;
      en      <= 1'b0;
    end else begin
      if (cmd_load) cmd_on <= cmd_bit;
      if (cmd_load && !cmd_bit)   latched <= 1'b0;
      else if (cmd_on && trip)    latched <= 1'b1;
      en <= cmd_on & ~latched & ~trip;
    end
  end

  assign stat = osw_status(en, oc, dh);
endmodule

// File: rtl/osw_ctrl.sv
`timescale 1ns/1ps
module osw_ctrl
  import osw_pkg::*;
#(
  parameter int unsigned CH   = OSW_CH_DEF,
  parameter int unsigned SYNC = OSW_SYNC_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          prot_dis,
  input  logic [CH-1:0] ovc,
  input  logic [CH-1:0] drain_hi,
  output logic [CH-1:0] out_en
);
  logic          sclk_s, cs_s, si_s, sclk_d, cs_d;
  logic          cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic          clr_act, pd_s, cmd_load;
  logic [CH-1:0] ovc_s, status, cmd_q, flt, cmd_word;

  osw_sync #(.W(3), .STAGES(SYNC), .INIT(3'b110)) u_pin_sync (
    .clk(clk), .rst(rst), .d({sclk, cs_n, si}), .q({sclk_s, cs_s, si_s}));

  osw_sync #(.W(CH + 1), .STAGES(SYNC), .INIT('0)) u_flag_sync (
    .clk(clk), .rst(rst), .d({prot_dis, ovc}), .q({pd_s, ovc_s}));

  osw_clr_sync #(.STAGES(SYNC)) u_clr_sync (
    .clk(clk), .clr_n(clr_n), .clr_act(clr_act));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign sclk_fall = sclk_d & ~sclk_s;
  assign sclk_rise = ~sclk_d & sclk_s;

  osw_frame #(.W(CH)) u_frame (
    .clk(clk), .rst(rst), .clr(clr_act),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .si_s(si_s), .status(status),
    .so(so), .so_oe(so_oe),
    .cmd_word(cmd_word), .cmd_load(cmd_load));

  for (genvar k = 0; k < CH; k++) begin : g_ch
    osw_channel u_ch (
      .clk(clk), .rst(rst), .clr(clr_act),
      .cmd_load(cmd_load), .cmd_bit(cmd_word[k]),
      .oc(ovc_s[k]), .pd(pd_s), .dh(drain_hi[k]),
      .cmd_on(cmd_q[k]), .latched(flt[k]),
      .en(out_en[k]), .stat(status[k]));
  end
endmodule

// File: rtl/osw_ctrl_chk.sv
`timescale 1ns/1ps
module osw_ctrl_chk #(
  parameter int unsigned CH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_act,
  input logic          cs_fall,
  input logic          cs_rise,
  input logic          sclk_rise,
  input logic          so,
  input logic          so_oe,
  input logic          cmd_load,
  input logic          pd_s,
  input logic [CH-1:0] status,
  input logic [CH-1:0] cmd_q,
  input logic [CH-1:0] flt,
  input logic [CH-1:0] ovc_s,
  input logic [CH-1:0] out_en
);
  assert_oe_on_R1: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> so_oe);

  assert_oe_off_R1: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !so_oe);

  assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (so == $past(status[CH-1])));

  assert_discard_R5: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !cmd_load && !clr_act) |=> (cmd_q == $past(cmd_q)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (out_en == '0 && cmd_q == '0 && flt == '0));

  assert_so_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_act && !cs_fall && !cs_rise && !sclk_rise) |=> ($stable(so) && $stable(so_oe)));

  for (genvar k = 0; k < CH; k++) begin : g_chk
    assert_trip_cause_R6: assert property (@(posedge clk) disable iff (rst)
      ($fell(out_en[k]) && $past(cmd_q[k]) && !$past(clr_act) && !$past(rst))
      |-> ($past(flt[k]) || ($past(ovc_s[k]) && !$past(pd_s))));

    assert_limit_keep_R8: assert property (@(posedge clk) disable iff (rst)
      (pd_s && $past(pd_s) && out_en[k] && cmd_q[k] && !clr_act && !cmd_load)
      |=> out_en[k]);
  end
endmodule

bind osw_ctrl osw_ctrl_chk #(.CH(CH)) u_chk (.*);

// File: tb/osw_ctrl_tb_top.sv
`timescale 1ns/1ps
module osw_ctrl_tb_top;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst, clr_n, sclk, cs_n, si, prot_dis;
  logic [7:0] ovc, drain_hi;
  logic so, so_oe;
  logic [7:0] out_en;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  osw_ctrl dut_i (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .prot_dis(prot_dis), .ovc(ovc),
    .drain_hi(drain_hi), .out_en(out_en));

  // {ovc, drain, prot_dis, cmd, bits, expected status, expected out_en}
  localparam logic [44:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 8'hA5, 4'd8, 8'hFF, 8'hA5},
    {8'h00, 8'h20, 1'b0, 8'h3C, 4'd8, 8'h7A, 8'h3C},
    {8'h04, 8'h00, 1'b0, 8'h3C, 4'd8, 8'hC7, 8'h38},
    {8'h00, 8'h00, 1'b0, 8'h3C, 4'd8, 8'hC7, 8'h38},
    {8'h00, 8'h00, 1'b0, 8'h38, 4'd8, 8'hC7, 8'h38},
    {8'h00, 8'h00, 1'b0, 8'h3C, 4'd8, 8'hC7, 8'h3C},
    {8'h10, 8'h00, 1'b1, 8'hFF, 4'd8, 8'hD3, 8'hFF},
    {8'h10, 8'h01, 1'b1, 8'h00, 4'd7, 8'h11, 8'hFF},
    {8'h00, 8'h00, 1'b0, 8'h00, 4'd9, 8'h00, 8'hFF},
    {8'h80, 8'h00, 1'b0, 8'hFF, 4'd8, 8'h80, 8'h7F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, output logic s);
    si = b;
    repeat (4) @(negedge clk);
    s = so;
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
  endtask

  task automatic frame(input logic [15:0] word, input int n, output logic [15:0] rcv);
    logic s;
    rcv = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 so_oe in frame", {15'd0, so_oe}, 16'd1);
    for (int b = n - 1; b >= 0; b--) begin
      shift_bit(word[b], s);
      rcv = {rcv[14:0], s};
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 so_oe after frame", {15'd0, so_oe}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rcv;
    logic s, so_keep;
    rst = 1'b1; clr_n = 1'b1; sclk = 1'b1; cs_n = 1'b1; si = 1'b0;
    prot_dis = 1'b0; ovc = '0; drain_hi = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 reset out_en", {8'd0, out_en}, 16'h0000);
    chk("R11 reset so_oe", {15'd0, so_oe}, 16'd0);

    // R2 R3 R4 R5 R6 R7 R8: table of frames
    for (int r = 0; r < NV; r++) begin
      logic [44:0] v;
      int n;
      v = VEC[r];
      ovc = v[44:37]; drain_hi = v[36:29]; prot_dis = v[28];
      n = int'(v[19:16]);
      repeat (12) @(negedge clk);
      frame({8'd0, v[27:20]}, n, rcv);
      if (n <= 8)
        chk("R2 R4 status word", rcv, {8'd0, v[15:8]} >> (8 - n));
      else
        chk("R2 R4 status word", rcv >> (n - 8), {8'd0, v[15:8]});
      chk("R3 R5 R6 R7 R8 out_en", {8'd0, out_en}, {8'd0, v[7:0]});
    end

    // R9 R10: clear pulse in the middle of a frame
    ovc = '0;
    repeat (12) @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < 3; b++) shift_bit(1'b1, s);
    repeat (4) @(negedge clk);
    so_keep = so;
    clr_n = 1'b0;
    repeat (6) @(negedge clk);
    clr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 so kept across clear", {15'd0, so}, {15'd0, so_keep});
    chk("R10 so_oe kept across clear", {15'd0, so_oe}, 16'd1);
    chk("R9 out_en off after clear", {8'd0, out_en}, 16'h0000);
    for (int b = 0; b < 5; b++) shift_bit(1'b1, s);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 cleared frame discarded", {8'd0, out_en}, 16'h0000);

    // R7 R9: latch on channel 7 was cleared, it can turn on again
    frame(16'h0080, 8, rcv);
    chk("R4 status after clear", rcv, 16'h00FF);
    chk("R7 R9 channel 7 on again", {8'd0, out_en}, 16'h0080);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule